// File: doc/BRIEF.md
# Capture Input Delay Qualifier

This block sits between a timer capture pin and the capture logic and keeps short pulses from being taken as edges. The raw pin first passes through a synchronizer. An active edge, of the direction the edge mode selects, starts a wait of a programmable number of module clock cycles. At the end of the wait the block compares the synchronized pin level with the level it held just before the edge. If the two differ, the block emits a one-cycle qualified-edge pulse. If the pin has returned to its old level, the block emits nothing.

The delay select has four settings: off, 256, 512 and 1024 cycles. When it is off, the block passes every detected active edge straight through as a pulse. Correct operation assumes that active edges on the pin are spaced further apart than the selected wait.

Top module: `icap_glitch_filter`

## Requirements
- R1: During reset and after its release, with no pin activity, `qual_o` is 0 and the block is idle.
- R2: With `dly_sel_i` = 00 (bypass), the block forwards each active edge of the synchronized pin as a pulse one cycle after detection, with no level check. An edge of the other direction gives no pulse. With a 2-flop synchronizer, the pulse is high in the third cycle after the pin changes.
- R3: With `dly_sel_i` = 01, an active edge starts a 256-cycle wait. A pulse follows only if the synchronized level at the end of the wait differs from the level held before the edge.
- R4: If the pin is back at its pre-edge level when the wait ends, the block produces no pulse.
- R5: `dly_sel_i` = 10 selects a 512-cycle wait and 11 selects a 1024-cycle wait. In every mode the internal count stays below the selected length and clears when the wait ends.
- R6: Edges that arrive while a wait is running are ignored. The block returns to idle after every qualification decision.
- R7: `edge_sel_i` picks the active edge: 00 none, 01 rising, 10 falling, 11 both.
- R8: A change of `dly_sel_i` while a wait is running abandons the wait without a pulse.
- R9: Every pulse on `qual_o` lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw capture pin |
| edge_sel_i | input | 2 | Active edge: 00 none, 01 rise, 10 fall, 11 both |
| dly_sel_i | input | 2 | Delay: 00 bypass, 01 256, 10 512, 11 1024 cycles |
| qual_o | output | 1 | One-cycle qualified-edge pulse |

## Verification
The abort property assumes that once a wait has started, `dly_sel_i` changes only when an abort is intended. Under that assumption every change seen while busy must end the wait silently. The stimulus changes the delay select only while the block is idle, except in the one deliberate abort case. The wait properties also rely on active edges being spaced further apart than the selected delay. The stimulus holds each final level well beyond the wait, and it places glitches and extra toggles inside a running wait only to exercise rejection and edge masking.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  typedef enum logic [1:0] {
    DLY_OFF  = 2'b00,
    DLY_X1   = 2'b01,
    DLY_X2   = 2'b10,
    DLY_X4   = 2'b11
  } dly_sel_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } flt_state_e;

  function automatic int unsigned wait_cycles(input logic [1:0] sel, input int unsigned base);
    unique case (sel)
      DLY_X1:  wait_cycles = base;
      DLY_X2:  wait_cycles = base * 2;
      DLY_X4:  wait_cycles = base * 4;
      default: wait_cycles = 0;
    endcase
  endfunction
endpackage

// File: rtl/ifg_sync.sv
module ifg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ifg_edge_det.sv
module ifg_edge_det
  import ifg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  output logic       prev_o,
  output logic       hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/ifg_dly_cnt.sv
module ifg_dly_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else if (run_i)           cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/icap_glitch_filter.sv
module icap_glitch_filter
  import ifg_pkg::*;
#(
  parameter int BASE_DLY    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  input  logic [1:0] dly_sel_i,
  output logic       qual_o
);
  localparam int MAX_DLY = BASE_DLY * 4;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  logic             lvl, prev, hit;
  logic             start, abort, done, busy;
  logic [CNT_W-1:0] limit, cnt;
  flt_state_e       state_q;
  logic [1:0]       dly_q;
  logic             pre_q, qual_q;

  ifg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl)
  );

  ifg_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .mode_i(edge_sel_i),
    .prev_o(prev), .hit_o(hit)
  );

  assign busy  = (state_q == ST_WAIT);
  assign start = !busy && hit && (dly_sel_i != DLY_OFF);
  // any change of the select mid-wait abandons the wait
  assign abort = busy && (dly_sel_i != dly_q);
  assign limit = CNT_W'(wait_cycles(dly_q, BASE_DLY));

  ifg_dly_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start | abort), .run_i(busy && !abort),
    .limit_i(limit), .done_o(done), .cnt_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dly_q   <= DLY_OFF;
      pre_q   <= 1'b0;
      qual_q  <= 1'b0;
    end else begin
      qual_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hit && dly_sel_i == DLY_OFF) begin
            qual_q <= 1'b1;
          end else if (start) begin
            state_q <= ST_WAIT;
            dly_q   <= dly_sel_i;
            pre_q   <= prev;
          end
        end
        ST_WAIT: begin
          if (abort) begin
            state_q <= ST_IDLE;
          end else if (done) begin
            qual_q  <= (lvl != pre_q);
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/ifg_checker.sv
module ifg_checker #(
  parameter int CNT_W   = 11,
  parameter int MAX_DLY = 1024
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             qual_o,
  input logic             busy,
  input logic [1:0]       dly_sel_i,
  input logic [CNT_W-1:0] cnt
);
  a_r9_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |=> !qual_o);

  a_r8_abort_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !$stable(dly_sel_i)) |=> (!busy && !qual_o));

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (cnt < CNT_W'(MAX_DLY)));

  a_r5_cnt_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (cnt == '0));

  a_r3_pulse_after_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_o && $past(dly_sel_i) != 2'b00) |-> $past(busy));

  a_r2_bypass_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_sel_i == 2'b00 && !busy) |=> !busy);
endmodule

bind icap_glitch_filter ifg_checker #(.CNT_W(CNT_W), .MAX_DLY(MAX_DLY)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .qual_o(qual_o), .busy(busy),
  .dly_sel_i(dly_sel_i), .cnt(cnt)
);

// File: tb/icap_glitch_filter_bench.sv
`timescale 1ns/1ps
module icap_glitch_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic [1:0] esel = 2'b01;
  logic [1:0] dsel = 2'b00;
  logic qual;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int run_len = 0;
  int max_run = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  icap_glitch_filter u_icap_glitch_filter (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .edge_sel_i(esel),
    .dly_sel_i(dsel), .qual_o(qual)
  );

  // behavioural reference model
  bit hist[$] = '{0, 0, 0};
  bit exp_q = 0;
  int st = 0, n = 0, saved = 0;
  bit pre = 0;

  function automatic int dly_len(input int s);
    return (s == 0) ? 0 : (256 << (s - 1));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      exp_q = 0; st = 0; n = 0;
    end else begin
      bit s2, pv, det;
      s2 = hist[hist.size()-2];
      pv = hist[hist.size()-3];
      det = ((esel[0] && s2 && !pv) || (esel[1] && !s2 && pv));
      exp_q = 0;
      if (st == 0) begin
        if (det && dsel == 0) exp_q = 1;
        else if (det) begin st = 1; n = 0; pre = pv; saved = dsel; end
      end else begin
        if (int'(dsel) != saved) st = 0;
        else if (n == dly_len(saved) - 1) begin exp_q = (s2 != pre); st = 0; end
        else n++;
      end
      hist.push_back(pin);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (qual !== exp_q) begin
        errors++;
        $display("FAIL %s: qual_o=%0b expected %0b at %0t", cur_req, qual, exp_q, $time);
      end
      if (qual) begin pulses++; run_len++; if (run_len > max_run) max_run = run_len; end
      else run_len = 0;
    end
  end

  task automatic step(input bit v, input int cyc);
    @(negedge clk); pin = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic expect_pulses(input string req, input int want);
    checks++;
    if (pulses != want) begin
      errors++;
      $display("FAIL %s: pulses=%0d expected %0d", req, pulses, want);
    end
    pulses = 0;
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (qual !== 1'b0) begin errors++; $display("FAIL R1: qual_o=%0b expected 0 in reset", qual); end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    expect_pulses("R1", 0);

    cur_req = "R2";
    step(1, 10); step(0, 10); step(1, 10); step(0, 10);
    expect_pulses("R2", 2);

    cur_req = "R3";
    dsel = 2'b01;
    step(1, 300); step(0, 300);
    expect_pulses("R3", 1);

    cur_req = "R4";
    step(1, 50); step(0, 400);
    expect_pulses("R4", 0);

    cur_req = "R5";
    dsel = 2'b10;
    step(1, 600); step(0, 20);
    expect_pulses("R5", 1);
    dsel = 2'b11;
    step(1, 1100); step(0, 20);
    expect_pulses("R5", 1);
    step(1, 600); step(0, 600);
    expect_pulses("R4", 0);

    cur_req = "R6";
    dsel = 2'b01;
    step(1, 20); step(0, 20); step(1, 300); step(0, 20);
    expect_pulses("R6", 1);

    cur_req = "R7";
    esel = 2'b10;
    step(1, 300); step(0, 300);
    expect_pulses("R7", 1);
    esel = 2'b00;
    step(1, 300); step(0, 300);
    expect_pulses("R7", 0);
    esel = 2'b11;
    step(1, 300); step(0, 300);
    expect_pulses("R7", 2);

    cur_req = "R8";
    esel = 2'b01;
    step(1, 100);
    dsel = 2'b10;
    repeat (700) @(negedge clk);
    expect_pulses("R8", 0);
    dsel = 2'b01;
    step(0, 20);

    checks++;
    if (max_run != 1) begin
      errors++;
      $display("FAIL R9: longest pulse=%0d expected 1", max_run);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule